// File: doc/BRIEF.md
# Aperture Address Remapping Table

This block translates client bus addresses that fall inside a fixed aperture window into physical addresses, one 4 KiB page at a time. Each aperture page owns one flat table entry. An entry carries a valid flag in bit 31 and a physical page base in bits 30:12. A lookup port answers in the same cycle with the translated address and a hit or fault flag. Addresses outside the window, and every address while translation is off, pass through unchanged.

Software reaches the table only through a three-register window on a simple APB-style port. The register at offset 0x0 is the configuration register, and its bit 0 turns translation on. The register at 0x4 holds an aperture address that selects a page. The register at 0x8 is the data port of the selected entry. Reading the configuration register back returns what was last written, so software can use that read as a completion flush after a burst of table updates. The aperture base and the page count are fixed when the block is elaborated.

Top module: `aperture_remap`

## Requirements
- R1: Reset clears the configuration register and every table entry. After reset, offsets 0x0, 0x4 and 0x8 read zero, and lookups pass through with hit and fault low.
- R2: A write to offset 0x0 sets the enable to bit 0 of the write data. A read of 0x0 returns that bit in bit 0 with bits 31:1 zero.
- R3: Offset 0x4 holds the entry-address register. A read of 0x4 returns the full 32-bit value last written.
- R4: A write to offset 0x8 while the entry address lies inside the aperture stores bits 31:12 of the data in the selected entry. On readback, bits 11:0 of an entry are always zero.
- R5: The selected entry index is (entry_address − base) >> 12, so any entry address within one page selects the same entry. A read of 0x8 returns that entry.
- R6: When the entry address lies outside the aperture, a write to 0x8 changes no entry and a read of 0x8 returns zero.
- R7: With translation on, a lookup of an aperture address whose entry has bit 31 set returns {1'b0, entry[30:12], addr[11:0]} in the same cycle, with hit high and fault low.
- R8: With translation on, a lookup of an aperture address whose entry has bit 31 clear raises fault, keeps hit low and returns the address unchanged. Hit and fault are never high together.
- R9: While translation is off, every lookup returns its address unchanged with hit and fault low.
- R10: The aperture runs from base to base + pages × 4096 − 1 inclusive. The first and last byte translate. The byte just below base and the byte at base + pages × 4096 pass through unchanged.
- R11: Offset 0xC reads zero, and writes to it change neither the registers nor the table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 4 | Register byte offset |
| pwdata | input | 32 | Register write data |
| prdata | output | 32 | Register read data, valid in the read access phase |
| lk_addr | input | 32 | Client address to translate |
| lk_phys | output | 32 | Translated or passed-through address |
| lk_hit | output | 1 | Address translated through a valid entry |
| lk_fault | output | 1 | Aperture address with an invalid entry |

## Verification
The bench probes the window edges: the first byte, the last byte, the byte just below base and the byte one past the end. A design with an off-by-one limit would translate a byte it should pass through, or fault on a byte it should translate. It writes and reads through entry addresses outside the aperture on both sides and then reads the edge entries back, which exposes a design that wraps the index into the table and corrupts entries 0 or 63. It checks that page-offset bits in the entry address do not move the selection, that low data bits never appear on readback, and that a second reset wipes a filled table and the enable. It also turns translation off while valid entries remain, which catches a design that keeps translating after the enable is cleared.

// File: rtl/aperture_remap_pkg.sv
`timescale 1ns/1ps
package aperture_remap_pkg;

  localparam int unsigned PAGE_SHIFT = 12;
  localparam int unsigned ENT_W      = 32 - PAGE_SHIFT;

  typedef logic [ENT_W-1:0] entry_t;

  typedef enum logic [1:0] {
    REG_CFG   = 2'd0,
    REG_EADDR = 2'd1,
    REG_EDATA = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;

  // Byte address inside the aperture test: above base and within the page count.
  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] base,
                                     input int unsigned pages);
    logic [32:0] diff;
    diff = {1'b0, a} - {1'b0, base};
    return (diff[32] == 1'b0) && ({12'd0, diff[31:PAGE_SHIFT]} < pages);
  endfunction

  // Page number relative to the aperture base.
  function automatic logic [ENT_W-1:0] page_index(input logic [31:0] a,
                                                  input logic [31:0] base);
    logic [31:0] diff;
    diff = a - base;
    return diff[31:PAGE_SHIFT];
  endfunction

  function automatic logic entry_valid(input entry_t e);
    return e[ENT_W-1];
  endfunction

  // Physical address from a stored entry and the client page offset.
  function automatic logic [31:0] compose_phys(input entry_t e,
                                               input logic [31:0] a);
    return {1'b0, e[ENT_W-2:0], a[PAGE_SHIFT-1:0]};
  endfunction

endpackage

// File: rtl/remap_regs.sv
`timescale 1ns/1ps
module remap_regs
  import aperture_remap_pkg::*;
#(
  parameter logic [31:0] APER_BASE = 32'h4000_0000,
  parameter int unsigned PAGE_CNT  = 64,
  parameter int unsigned IDX_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [3:0]       paddr,
  input  logic [31:0]      pwdata,
  output logic [31:0]      prdata,
  output logic             cfg_en,
  output logic             eaddr_in_win,
  output logic [IDX_W-1:0] eaddr_idx,
  output logic             tbl_we,
  output entry_t           tbl_wdata,
  input  entry_t           tbl_rdata
);

  typedef logic [IDX_W-1:0] idx_t;

  reg_sel_e    sel;
  logic        acc_wr;
  logic        acc_rd;
  logic [31:0] eaddr_q;

  assign sel    = reg_sel_e'(paddr[3:2]);
  assign acc_wr = psel && penable && pwrite;
  assign acc_rd = psel && !pwrite;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en  <= 1'b0;
      eaddr_q <= '0;
    end else if (acc_wr) begin
      if (sel == REG_CFG)   cfg_en  <= pwdata[0];
      if (sel == REG_EADDR) eaddr_q <= pwdata;
    end
  end

  assign eaddr_in_win = in_window(eaddr_q, APER_BASE, PAGE_CNT);
  assign eaddr_idx    = idx_t'(page_index(eaddr_q, APER_BASE));
  assign tbl_we       = acc_wr && (sel == REG_EDATA) && eaddr_in_win;
  assign tbl_wdata    = pwdata[31:PAGE_SHIFT];

  always_comb begin
    prdata = '0;
    if (acc_rd) begin
      unique case (sel)
        REG_CFG:   prdata = {31'd0, cfg_en};
        REG_EADDR: prdata = eaddr_q;
        REG_EDATA: prdata = eaddr_in_win ? {tbl_rdata, {PAGE_SHIFT{1'b0}}} : '0;
        default:   prdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/remap_table.sv
`timescale 1ns/1ps
module remap_table
  import aperture_remap_pkg::*;
#(
  parameter int unsigned PAGE_CNT = 64,
  parameter int unsigned IDX_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  entry_t           wdata,
  input  logic [IDX_W-1:0] sw_idx,
  output entry_t           sw_rdata,
  input  logic [IDX_W-1:0] lk_idx,
  output entry_t           lk_rdata
);

  typedef logic [IDX_W-1:0] idx_t;

  entry_t ent_q [PAGE_CNT];

  for (genvar g = 0; g < PAGE_CNT; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ent_q[g] <= '0;
      else if (we && (widx == idx_t'(g)))
        ent_q[g] <= wdata;
    end
  end

  assign sw_rdata = ({{(32-IDX_W){1'b0}}, sw_idx} < PAGE_CNT) ? ent_q[sw_idx] : '0;
  assign lk_rdata = ({{(32-IDX_W){1'b0}}, lk_idx} < PAGE_CNT) ? ent_q[lk_idx] : '0;

endmodule

// File: rtl/remap_lookup.sv
`timescale 1ns/1ps
module remap_lookup
  import aperture_remap_pkg::*;
#(
  parameter logic [31:0] APER_BASE = 32'h4000_0000,
  parameter int unsigned PAGE_CNT  = 64,
  parameter int unsigned IDX_W     = 6
) (
  input  logic [31:0]      lk_addr,
  input  logic             cfg_en,
  output logic [IDX_W-1:0] lk_idx,
  input  entry_t           lk_entry,
  output logic             lk_in_win,
  output logic [31:0]      lk_phys,
  output logic             lk_hit,
  output logic             lk_fault
);

  typedef logic [IDX_W-1:0] idx_t;

  logic active;

  assign lk_in_win = in_window(lk_addr, APER_BASE, PAGE_CNT);
  assign lk_idx    = idx_t'(page_index(lk_addr, APER_BASE));
  assign active    = cfg_en && lk_in_win;

  always_comb begin
    lk_phys  = lk_addr;
    lk_hit   = 1'b0;
    lk_fault = 1'b0;
    if (active) begin
      if (entry_valid(lk_entry)) begin
        lk_phys = compose_phys(lk_entry, lk_addr);
        lk_hit  = 1'b1;
      end else begin
        lk_fault = 1'b1;
      end
    end
  end

endmodule

// File: rtl/aperture_remap.sv
`timescale 1ns/1ps
module aperture_remap
  import aperture_remap_pkg::*;
#(
  parameter logic [31:0] APER_BASE = 32'h4000_0000,
  parameter int unsigned PAGE_CNT  = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [3:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  input  logic [31:0] lk_addr,
  output logic [31:0] lk_phys,
  output logic        lk_hit,
  output logic        lk_fault
);

  localparam int unsigned IDX_W = (PAGE_CNT > 1) ? $clog2(PAGE_CNT) : 1;

  logic             cfg_en;
  logic             eaddr_in_win;
  logic [IDX_W-1:0] eaddr_idx;
  logic             tbl_we;
  entry_t           tbl_wdata;
  entry_t           sw_rdata;
  logic [IDX_W-1:0] lk_idx;
  entry_t           lk_rdata;
  logic             lk_in_win;

  remap_regs #(
    .APER_BASE (APER_BASE),
    .PAGE_CNT  (PAGE_CNT),
    .IDX_W     (IDX_W)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .psel         (psel),
    .penable      (penable),
    .pwrite       (pwrite),
    .paddr        (paddr),
    .pwdata       (pwdata),
    .prdata       (prdata),
    .cfg_en       (cfg_en),
    .eaddr_in_win (eaddr_in_win),
    .eaddr_idx    (eaddr_idx),
    .tbl_we       (tbl_we),
    .tbl_wdata    (tbl_wdata),
    .tbl_rdata    (sw_rdata)
  );

  remap_table #(
    .PAGE_CNT (PAGE_CNT),
    .IDX_W    (IDX_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (tbl_we),
    .widx     (eaddr_idx),
    .wdata    (tbl_wdata),
    .sw_idx   (eaddr_idx),
    .sw_rdata (sw_rdata),
    .lk_idx   (lk_idx),
    .lk_rdata (lk_rdata)
  );

  remap_lookup #(
    .APER_BASE (APER_BASE),
    .PAGE_CNT  (PAGE_CNT),
    .IDX_W     (IDX_W)
  ) u_lookup (
    .lk_addr   (lk_addr),
    .cfg_en    (cfg_en),
    .lk_idx    (lk_idx),
    .lk_entry  (lk_rdata),
    .lk_in_win (lk_in_win),
    .lk_phys   (lk_phys),
    .lk_hit    (lk_hit),
    .lk_fault  (lk_fault)
  );

endmodule

// File: rtl/aperture_remap_chk.sv
`timescale 1ns/1ps
module aperture_remap_chk #(
  parameter logic [31:0] APER_BASE = 32'h4000_0000,
  parameter int unsigned PAGE_CNT  = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [3:0]  paddr,
  input logic [31:0] pwdata,
  input logic [31:0] lk_addr,
  input logic [31:0] lk_phys,
  input logic        lk_hit,
  input logic        lk_fault,
  input logic        cfg_en,
  input logic        tbl_we,
  input logic        eaddr_in_win
);

  logic [32:0] span_end;
  logic        lk_outside;
  logic        cfg_wr;
  logic        data_wr;

  assign span_end   = {1'b0, APER_BASE} + (33'(PAGE_CNT) << 12);
  assign lk_outside = ({1'b0, lk_addr} < {1'b0, APER_BASE}) || ({1'b0, lk_addr} >= span_end);
  assign cfg_wr     = psel && penable && pwrite && (paddr[3:2] == 2'd0);
  assign data_wr    = psel && penable && pwrite && (paddr[3:2] == 2'd2);

  AST_CFG_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_en == $past(pwdata[0]))); // R2

  AST_TABLE_WRITE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> data_wr); // R11

  AST_OUTSIDE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    !eaddr_in_win |-> !tbl_we); // R6

  AST_HIT_KEEPS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_phys[11:0] == lk_addr[11:0]) && !lk_phys[31]); // R7

  AST_HIT_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_fault)); // R8

  AST_FAULT_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> (lk_phys == lk_addr)); // R8

  AST_OFF_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> (lk_phys == lk_addr) && !lk_hit && !lk_fault); // R9

  AST_EDGE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    lk_outside |-> (lk_phys == lk_addr) && !lk_hit && !lk_fault); // R10

endmodule

bind aperture_remap aperture_remap_chk #(
  .APER_BASE (APER_BASE),
  .PAGE_CNT  (PAGE_CNT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .psel         (psel),
  .penable      (penable),
  .pwrite       (pwrite),
  .paddr        (paddr),
  .pwdata       (pwdata),
  .lk_addr      (lk_addr),
  .lk_phys      (lk_phys),
  .lk_hit       (lk_hit),
  .lk_fault     (lk_fault),
  .cfg_en       (cfg_en),
  .tbl_we       (tbl_we),
  .eaddr_in_win (eaddr_in_win)
);

// File: tb/aperture_remap_test.sv
`timescale 1ns/1ps
module aperture_remap_test;

  localparam logic [31:0] BASE  = 32'h4000_0000;
  localparam int unsigned PAGES = 64;
  localparam longint      SPAN  = longint'(PAGES) * 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [3:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [31:0] lk_addr = '0;
  logic [31:0] lk_phys;
  logic        lk_hit;
  logic        lk_fault;
  logic        lk_chk = 1'b0;

  always #2.5 clk = ~clk;

  aperture_remap #(.APER_BASE(BASE), .PAGE_CNT(PAGES)) uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .lk_addr(lk_addr), .lk_phys(lk_phys), .lk_hit(lk_hit), .lk_fault(lk_fault)
  );

  typedef struct {
    bit          is_lk;
    logic [31:0] d;
    logic        h;
    logic        f;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_vec = 0;
  int    n_bad = 0;

  // Bench-side model of the programmable state.
  logic        m_cfg = 1'b0;
  logic [31:0] m_ea  = '0;
  logic [31:0] m_tbl [PAGES];

  function automatic bit m_inwin(input logic [31:0] a);
    longint la = longint'(a);
    longint lb = longint'(BASE);
    return (la >= lb) && (la < lb + SPAN);
  endfunction

  function automatic int m_page(input logic [31:0] a);
    return int'((longint'(a) - longint'(BASE)) / 4096);
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] off);
    case (off)
      4'h0: return {31'd0, m_cfg};
      4'h4: return m_ea;
      4'h8: return m_inwin(m_ea) ? m_tbl[m_page(m_ea)] : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_clear();
    m_cfg = 1'b0;
    m_ea  = '0;
    for (int i = 0; i < PAGES; i++) m_tbl[i] = '0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    model_clear();
  endtask

  task automatic reg_write(input logic [3:0] off, input logic [31:0] data);
    @(posedge clk); #1;
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = off; pwdata = data;
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    case (off)
      4'h0: m_cfg = data[0];
      4'h4: m_ea  = data;
      4'h8: if (m_inwin(m_ea)) m_tbl[m_page(m_ea)] = data & 32'hFFFF_F000;
      default: ;
    endcase
  endtask

  task automatic reg_read(input logic [3:0] off, input string tag);
    item_t it;
    @(posedge clk); #1;
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = off;
    @(posedge clk); #1;
    it.is_lk = 1'b0; it.d = m_read(off); it.h = 1'b0; it.f = 1'b0; it.tag = tag;
    q.push_back(it);
    penable = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic look(input logic [31:0] a, input string tag);
    item_t it;
    logic [31:0] e;
    it.is_lk = 1'b1; it.tag = tag; it.d = a; it.h = 1'b0; it.f = 1'b0;
    if (m_cfg && m_inwin(a)) begin
      e = m_tbl[m_page(a)];
      if (e[31]) begin
        it.d = {1'b0, e[30:12], a[11:0]};
        it.h = 1'b1;
      end else begin
        it.f = 1'b1;
      end
    end
    @(posedge clk); #1;
    lk_addr = a;
    q.push_back(it);
    lk_chk = 1'b1;
    @(posedge clk); #1;
    lk_chk = 1'b0;
  endtask

  // Monitor: compares design outputs against queued expectations.
  initial begin
    forever begin
      @(negedge clk);
      if ((psel && penable && !pwrite) || lk_chk) begin
        if (q.size() == 0) begin
          n_vec++; n_bad++;
          $display("FAIL scoreboard: result with no expectation queued");
        end else begin
          item_t it;
          it = q.pop_front();
          n_vec++;
          if (!it.is_lk) begin
            if (prdata !== it.d) begin
              n_bad++;
              $display("FAIL %s: prdata=%h expected %h", it.tag, prdata, it.d);
            end
          end else if (lk_phys !== it.d || lk_hit !== it.h || lk_fault !== it.f) begin
            n_bad++;
            $display("FAIL %s: phys=%h hit=%b fault=%b expected phys=%h hit=%b fault=%b",
                     it.tag, lk_phys, lk_hit, lk_fault, it.d, it.h, it.f);
          end
        end
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    model_clear();
    do_reset();

    // R1: state after reset
    reg_read(4'h0, "R1 cfg after reset");
    reg_read(4'h4, "R1 eaddr after reset");
    for (int i = 0; i < PAGES; i++) begin
      reg_write(4'h4, BASE + 32'(i) * 32'd4096);
      reg_read(4'h8, "R1 entry after reset");
    end
    look(BASE + 32'h123, "R1 lookup after reset");

    // R2: enable bit only
    reg_write(4'h0, 32'h1);
    reg_read(4'h0, "R2 cfg on");
    reg_write(4'h0, 32'hFFFF_FFFE);
    reg_read(4'h0, "R2 cfg upper bits dropped");
    reg_write(4'h0, 32'h0);
    reg_read(4'h0, "R2 cfg off");

    // R3: entry address register readback
    reg_write(4'h4, 32'h1234_5678);
    reg_read(4'h4, "R3 eaddr readback");

    // R4: fill the table; odd pages valid, even pages hold a base without the valid bit
    for (int i = 0; i < PAGES; i++) begin
      logic [31:0] v;
      v = ((32'(i) * 32'h111 + 32'h7) << 12) | 32'h0000_0ABC;
      v[31] = i[0];
      reg_write(4'h4, BASE + 32'(i) * 32'd4096);
      reg_write(4'h8, v);
    end
    reg_write(4'h4, BASE + 32'd5 * 32'd4096);
    reg_read(4'h8, "R4 entry 5 low bits cleared");
    reg_write(4'h4, BASE + 32'd6 * 32'd4096);
    reg_read(4'h8, "R4 entry 6");

    // R5: page-offset bits in the entry address do not change the selection
    reg_write(4'h4, BASE + 32'd5 * 32'd4096 + 32'hFFC);
    reg_read(4'h8, "R5 same page high offset");
    reg_write(4'h4, BASE + 32'd33 * 32'd4096 + 32'h004);
    reg_read(4'h8, "R5 entry 33");

    // R6: entry address outside the aperture on both sides
    reg_write(4'h4, BASE - 32'd4);
    reg_write(4'h8, 32'hFFFF_FFFF);
    reg_read(4'h8, "R6 read below window");
    reg_write(4'h4, BASE + 32'(PAGES) * 32'd4096);
    reg_write(4'h8, 32'hFFFF_FFFF);
    reg_read(4'h8, "R6 read past window");
    reg_write(4'h4, BASE);
    reg_read(4'h8, "R6 entry 0 untouched");
    reg_write(4'h4, BASE + 32'(PAGES - 1) * 32'd4096);
    reg_read(4'h8, "R6 last entry untouched");

    // R11: unused offset
    reg_write(4'hC, 32'hDEAD_BEEF);
    reg_read(4'hC, "R11 unused offset reads zero");
    reg_read(4'h0, "R11 cfg unchanged");
    reg_read(4'h4, "R11 eaddr unchanged");
    reg_read(4'h8, "R11 entry unchanged");

    // R9: translation off while valid entries exist
    look(BASE + 32'd1 * 32'd4096 + 32'h010, "R9 disabled valid page");
    look(BASE + 32'd2 * 32'd4096 + 32'h010, "R9 disabled invalid page");

    // R7 / R8: translation on
    reg_write(4'h0, 32'h1);
    for (int i = 0; i < 8; i++) begin
      look(BASE + 32'(i * 7) * 32'd4096 + 32'(i * 291), i[0] ? "R7 hit" : "R8 fault");
    end
    look(BASE + 32'd9 * 32'd4096 + 32'hFFF, "R7 hit top offset");
    look(BASE + 32'd10 * 32'd4096, "R8 fault page 10");

    // R10: window edges
    look(BASE, "R10 first byte");
    look(BASE + 32'(PAGES) * 32'd4096 - 32'd1, "R10 last byte");
    look(BASE - 32'd1, "R10 below base");
    look(BASE + 32'(PAGES) * 32'd4096, "R10 one past end");
    look(32'h0000_0000, "R10 address zero");
    look(32'hFFFF_FFFF, "R10 top address");

    // R9 again after turning translation off
    reg_write(4'h0, 32'h0);
    look(BASE + 32'd63 * 32'd4096 + 32'h5A5, "R9 disabled after on");

    // R1: a second reset clears the filled table and the enable
    reg_write(4'h0, 32'h1);
    do_reset();
    reg_read(4'h0, "R1 cfg after second reset");
    look(BASE + 32'd3 * 32'd4096 + 32'h44, "R1 lookup after second reset");
    reg_write(4'h0, 32'h1);
    look(BASE + 32'd3 * 32'd4096 + 32'h44, "R1 entry cleared faults");
    for (int i = 0; i < PAGES; i += 9) begin
      reg_write(4'h4, BASE + 32'(i) * 32'd4096);
      reg_read(4'h8, "R1 entry cleared by second reset");
    end

    repeat (4) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule